// File: doc/BRIEF.md
# Write-Protect Control and Status Register

This block holds the write-protection state of a small device that combines a nonvolatile memory array with digital potentiometers. It keeps two enable latches, a write-enable latch and a register-write-enable latch, and a two-bit lock field. A decoded register port writes and reads this state one byte at a time. The enable latches can only be set by fixed command bytes written in order. The lock field changes only when a third byte of the right form follows them.

A second port answers permission questions. The surrounding logic presents a write kind, a memory address, the level of the external write-protect pin and a flag that says whether the bus transfer had the correct clock count and bit pattern before its stop condition. One cycle later the block returns a single-cycle grant or denial. The decision combines the latches, the lock field and the pin. The serial bus engine, the array itself and the programming timer live outside this block.

Top module: `wprot_csr`

## Requirements
- R1: A synchronous active-high reset clears both enable latches, returns the sequence tracker to idle and loads the lock field with parameter LOCK_INIT (default 0). While reset is high, csr_rd_valid and perm_valid stay low.
- R2: From idle, writing 02h sets the write-enable latch. Any other byte written in idle changes nothing. Writing 02h again while only the write-enable latch is set keeps that state.
- R3: While the write-enable latch is set and the register-write-enable latch is clear, writing 06h sets the register-write-enable latch. Writing 06h in idle does not set it.
- R4: While both latches are set, a byte whose bits 7:5 are 000 and bits 2:0 are 010 commits its bits 4:3 to the lock field, clears the register-write-enable latch and keeps the write-enable latch set. The byte sequence 02h, 06h, 02h therefore clears the lock field to 00.
- R5: Any byte that is not the expected next byte of the sequence (00h included) clears both latches and returns the tracker to idle. The lock field keeps its value.
- R6: While wp_pin is high, the committing byte of R4 leaves the lock field unchanged. It still clears the register-write-enable latch.
- R7: A read strobe returns csr_rd_valid high for exactly one cycle, on the next cycle, with data {000, lock[1], lock[0], register-write-enable, write-enable, 0}. Bits 7:5 and 0 always read as 0. A read does not disturb the state or a sequence in progress. A read in the same cycle as a write returns the state from before that write.
- R8: A memory write (kind 0) is granted only if the write-enable latch is set, wp_pin is low, the sequence flag is high and the address lies outside the locked region. Lock 00 locks nothing, 01 locks the top quarter (top two address bits 11), 10 locks the top half (top bit 1) and 11 locks the whole array.
- R9: A volatile potentiometer write (kind 1) is granted exactly when the write-enable latch is set, regardless of the pin, the lock field and the sequence flag.
- R10: A nonvolatile potentiometer write (kind 2) is granted only if the write-enable latch is set, wp_pin is low, the lock field is 00 and the sequence flag is high.
- R11: A register volatile-bit write (kind 3) is granted when both latches are set. A register nonvolatile-bit write (kind 4) additionally needs wp_pin low and the sequence flag high. Kinds 5 to 7 are always denied.
- R12: perm_valid is high exactly one cycle after req_valid, and perm_grant is never high without it. The decision uses the state from before any register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_data | input | 8 | Register write byte |
| csr_rd_en | input | 1 | Register read strobe |
| csr_rd_valid | output | 1 | Read data valid, one cycle after strobe |
| csr_rd_data | output | 8 | Register image |
| wp_pin | input | 1 | External write-protect level, high protects |
| req_valid | input | 1 | Permission request strobe |
| req_kind | input | 3 | Write kind, codes 0 to 4 as in R8 to R11 |
| req_addr | input | ADDR_W | Memory address of the request |
| req_seq_ok | input | 1 | Bus transfer had a correct clock count and bit pattern before stop |
| perm_valid | output | 1 | Decision valid, one cycle after request |
| perm_grant | output | 1 | Write allowed |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. That covers read data after a read strobe and a grant after a request, and a register write shows up in the next read. The bench drives each stimulus just after a falling edge. At that moment it takes the expected result from its model state before applying any write, then updates the model. It compares at the next falling edge, after the single register stage has captured the result. Directed sequences cover each lock region boundary, the pin during a commit, broken sequences and a read and a write in the same cycle. A long stretch of weighted random traffic follows them.

// File: rtl/wprot_csr_pkg.sv
`timescale 1ns/1ps
package wprot_csr_pkg;

    localparam int DATA_W = 8;
    localparam int KIND_W = 3;
    localparam int KIND_SPACE = 1 << KIND_W;

    // write kinds presented on the permission port
    localparam int KIND_MEM     = 0;
    localparam int KIND_POT_VOL = 1;
    localparam int KIND_POT_NV  = 2;
    localparam int KIND_CSR_VOL = 3;
    localparam int KIND_CSR_NV  = 4;

    localparam logic [DATA_W-1:0] CMD_ARM_WR  = 8'h02;
    localparam logic [DATA_W-1:0] CMD_ARM_CSR = 8'h06;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WEN  = 2'd1,
        SEQ_RWEN = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       wel;
        logic       rwel;
        logic [1:0] lock;
    } csr_state_t;

    // byte that may commit the lock field: 000 xx 010
    function automatic logic is_commit_byte(input logic [DATA_W-1:0] d);
        return (d[7:5] == 3'b000) && (d[2:0] == 3'b010);
    endfunction

    // locked-region test on the two top address bits
    function automatic logic lock_hit(input logic [1:0] lock, input logic [1:0] top2);
        logic hit;
        unique case (lock)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (top2 == 2'b11);
            2'b10:   hit = top2[1];
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction

    function automatic logic [DATA_W-1:0] csr_image(input csr_state_t st);
        return {3'b000, st.lock[1], st.lock[0], st.rwel, st.wel, 1'b0};
    endfunction

endpackage

// File: rtl/wprot_csr_seq.sv
`timescale 1ns/1ps
module wprot_csr_seq
    import wprot_csr_pkg::*;
#(
    parameter logic [1:0] LOCK_INIT = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wp_pin,
    output csr_state_t        st
);

    seq_state_e phase_q, phase_d;
    logic [1:0] lock_q, lock_d;

    always_comb begin
        phase_d = phase_q;
        lock_d  = lock_q;
        if (wr_en) begin
            unique case (phase_q)
                SEQ_IDLE: begin
                    if (wr_data == CMD_ARM_WR) phase_d = SEQ_WEN;
                end
                SEQ_WEN: begin
                    if (wr_data == CMD_ARM_WR)       phase_d = SEQ_WEN;
                    else if (wr_data == CMD_ARM_CSR) phase_d = SEQ_RWEN;
                    else                             phase_d = SEQ_IDLE;
                end
                SEQ_RWEN: begin
                    if (is_commit_byte(wr_data)) begin
                        phase_d = SEQ_WEN;
                        if (!wp_pin) lock_d = wr_data[4:3];
                    end else begin
                        phase_d = SEQ_IDLE;
                    end
                end
                default: phase_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= SEQ_IDLE;
            lock_q  <= LOCK_INIT;
        end else begin
            phase_q <= phase_d;
            lock_q  <= lock_d;
        end
    end

    assign st.wel  = (phase_q != SEQ_IDLE);
    assign st.rwel = (phase_q == SEQ_RWEN);
    assign st.lock = lock_q;

endmodule

// File: rtl/wprot_csr_perm.sv
`timescale 1ns/1ps
module wprot_csr_perm
    import wprot_csr_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  csr_state_t        st,
    input  logic              wp_pin,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_seq_ok,
    output logic              perm_valid,
    output logic              perm_grant
);

    localparam int TOP_LSB = ADDR_W - 2;

    logic [1:0]            top2;
    logic                  in_lock;
    logic [KIND_SPACE-1:0] grant_vec;

    assign top2    = req_addr[ADDR_W-1:TOP_LSB];
    assign in_lock = lock_hit(st.lock, top2);

    for (genvar k = 0; k < KIND_SPACE; k++) begin : g_kind
        if (k == KIND_MEM) begin : g_mem
            assign grant_vec[k] = st.wel & ~wp_pin & req_seq_ok & ~in_lock;
        end else if (k == KIND_POT_VOL) begin : g_pot_vol
            assign grant_vec[k] = st.wel;
        end else if (k == KIND_POT_NV) begin : g_pot_nv
            assign grant_vec[k] = st.wel & ~wp_pin & req_seq_ok & (st.lock == 2'b00);
        end else if (k == KIND_CSR_VOL) begin : g_csr_vol
            assign grant_vec[k] = st.wel & st.rwel;
        end else if (k == KIND_CSR_NV) begin : g_csr_nv
            assign grant_vec[k] = st.wel & st.rwel & ~wp_pin & req_seq_ok;
        end else begin : g_none
            assign grant_vec[k] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            perm_valid <= 1'b0;
            perm_grant <= 1'b0;
        end else begin
            perm_valid <= req_valid;
            perm_grant <= req_valid & grant_vec[req_kind];
        end
    end

endmodule

// File: rtl/wprot_csr_rdport.sv
`timescale 1ns/1ps
module wprot_csr_rdport
    import wprot_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  csr_state_t        st,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? csr_image(st) : '0;
        end
    end

endmodule

// File: rtl/wprot_csr.sv
`timescale 1ns/1ps
module wprot_csr
    import wprot_csr_pkg::*;
#(
    parameter int         ADDR_W    = 11,
    parameter logic [1:0] LOCK_INIT = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr_en,
    input  logic [7:0]        csr_wr_data,
    input  logic              csr_rd_en,
    output logic              csr_rd_valid,
    output logic [7:0]        csr_rd_data,
    input  logic              wp_pin,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_seq_ok,
    output logic              perm_valid,
    output logic              perm_grant
);

    csr_state_t csr_st;

    wprot_csr_seq #(
        .LOCK_INIT (LOCK_INIT)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (csr_wr_en),
        .wr_data (csr_wr_data),
        .wp_pin  (wp_pin),
        .st      (csr_st)
    );

    wprot_csr_perm #(
        .ADDR_W (ADDR_W)
    ) u_perm (
        .clk        (clk),
        .rst        (rst),
        .st         (csr_st),
        .wp_pin     (wp_pin),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_addr   (req_addr),
        .req_seq_ok (req_seq_ok),
        .perm_valid (perm_valid),
        .perm_grant (perm_grant)
    );

    wprot_csr_rdport u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (csr_rd_en),
        .st       (csr_st),
        .rd_valid (csr_rd_valid),
        .rd_data  (csr_rd_data)
    );

endmodule

// File: rtl/wprot_csr_chk.sv
`timescale 1ns/1ps
module wprot_csr_chk (
    input logic       clk,
    input logic       rst,
    input logic       csr_rd_en,
    input logic       csr_rd_valid,
    input logic [7:0] csr_rd_data,
    input logic       wp_pin,
    input logic       req_valid,
    input logic [2:0] req_kind,
    input logic       perm_valid,
    input logic       perm_grant,
    input logic       st_wel
);

    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    // R7
    rd_fixed_zero_chk: assert property (@(posedge clk) disable iff (rst)
        csr_rd_valid |-> (csr_rd_data[7:5] == 3'b000 && csr_rd_data[0] == 1'b0));

    // R7
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        seen |-> (csr_rd_valid == $past(csr_rd_en)));

    // R12
    perm_latency_chk: assert property (@(posedge clk) disable iff (rst)
        seen |-> (perm_valid == $past(req_valid)));

    // R12
    grant_in_valid_chk: assert property (@(posedge clk) disable iff (rst)
        perm_grant |-> perm_valid);

    // R8
    wp_blocks_nv_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && perm_valid && $past(wp_pin) &&
         ($past(req_kind) == 3'd0 || $past(req_kind) == 3'd2 || $past(req_kind) == 3'd4))
        |-> !perm_grant);

    // R9
    pot_vol_follows_wel_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && perm_valid && $past(req_kind) == 3'd1) |-> (perm_grant == $past(st_wel)));

    // R11
    unknown_kind_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && perm_valid && $past(req_kind) > 3'd4) |-> !perm_grant);

endmodule

bind wprot_csr wprot_csr_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .csr_rd_en    (csr_rd_en),
    .csr_rd_valid (csr_rd_valid),
    .csr_rd_data  (csr_rd_data),
    .wp_pin       (wp_pin),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .perm_valid   (perm_valid),
    .perm_grant   (perm_grant),
    .st_wel       (csr_st.wel)
);

// File: tb/wprot_csr_bench.sv
`timescale 1ns/1ps
module wprot_csr_bench;

    localparam int ADDR_W = 11;
    localparam int WATCHDOG = 100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              csr_wr_en = 1'b0;
    logic [7:0]        csr_wr_data = '0;
    logic              csr_rd_en = 1'b0;
    logic              csr_rd_valid;
    logic [7:0]        csr_rd_data;
    logic              wp_pin = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_kind = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_seq_ok = 1'b0;
    logic              perm_valid;
    logic              perm_grant;

    always #2.5 clk = ~clk;

    wprot_csr #(.ADDR_W(ADDR_W)) u_wprot_csr (
        .clk(clk), .rst(rst),
        .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
        .csr_rd_en(csr_rd_en), .csr_rd_valid(csr_rd_valid), .csr_rd_data(csr_rd_data),
        .wp_pin(wp_pin),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_seq_ok(req_seq_ok),
        .perm_valid(perm_valid), .perm_grant(perm_grant)
    );

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string tag = "R1";

    // reference model state
    bit       m_wel = 0, m_rwel = 0;
    bit [1:0] m_lock = 2'b00;

    function automatic bit mem_locked(bit [1:0] lk, int addr);
        int span = 1 << ADDR_W;
        int first;
        case (lk)
            2'd0:    first = span;
            2'd1:    first = (span / 4) * 3;
            2'd2:    first = span / 2;
            default: first = 0;
        endcase
        return addr >= first;
    endfunction

    function automatic bit model_grant(int kind, int addr, bit sq, bit wp);
        case (kind)
            0:       return m_wel && !wp && sq && !mem_locked(m_lock, addr);
            1:       return m_wel;
            2:       return m_wel && !wp && sq && (m_lock == 2'b00);
            3:       return m_wel && m_rwel;
            4:       return m_wel && m_rwel && !wp && sq;
            default: return 0;
        endcase
    endfunction

    function automatic string kind_tag(int kind);
        case (kind)
            0:       return "R8";
            1:       return "R9";
            2:       return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic model_write(bit [7:0] d, bit wp);
        if (!m_wel) begin
            if (d == 8'h02) m_wel = 1;
        end else if (!m_rwel) begin
            if (d == 8'h06) m_rwel = 1;
            else if (d != 8'h02) m_wel = 0;
        end else begin
            if (d[7:5] == 3'b000 && d[2:0] == 3'b010) begin
                m_rwel = 0;
                if (!wp) m_lock = d[4:3];
            end else begin
                m_wel = 0;
                m_rwel = 0;
            end
        end
    endtask

    // one clock: expectation from pre-state, model update, compare after the edge
    task automatic step();
        bit       e_rdv, e_pv, e_pg;
        bit [7:0] e_rdd;
        string    ktag;
        ktag = kind_tag(int'(req_kind));
        if (rst) begin
            e_rdv = 0; e_pv = 0; e_pg = 0; e_rdd = 8'h00;
            m_wel = 0; m_rwel = 0; m_lock = 2'b00;
        end else begin
            e_rdv = csr_rd_en;
            e_rdd = {3'b000, m_lock, m_rwel, m_wel, 1'b0};
            e_pv  = req_valid;
            e_pg  = req_valid && model_grant(int'(req_kind), int'(req_addr), req_seq_ok, wp_pin);
            if (csr_wr_en) model_write(csr_wr_data, wp_pin);
        end
        @(negedge clk);
        vectors++;
        if (csr_rd_valid !== e_rdv || (e_rdv && csr_rd_data !== e_rdd)) begin
            miscompares++;
            $display("FAIL %s read: valid=%0b data=%02h expected valid=%0b data=%02h",
                     tag, csr_rd_valid, csr_rd_data, e_rdv, e_rdd);
        end
        vectors++;
        if (perm_valid !== e_pv) begin
            miscompares++;
            $display("FAIL R12 perm_valid=%0b expected %0b (%s)", perm_valid, e_pv, tag);
        end else if (perm_grant !== e_pg) begin
            miscompares++;
            $display("FAIL %s grant=%0b expected %0b (scenario %s)", ktag, perm_grant, e_pg, tag);
        end
        csr_wr_en = 0; csr_rd_en = 0; req_valid = 0;
    endtask

    task automatic wr(bit [7:0] d);
        csr_wr_en = 1; csr_wr_data = d; step();
    endtask

    task automatic rd();
        csr_rd_en = 1; step();
    endtask

    task automatic rq(int kind, int addr, bit sq);
        req_valid = 1; req_kind = 3'(kind); req_addr = ADDR_W'(addr); req_seq_ok = sq; step();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            miscompares++;
            $display("FAIL R12 watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: outputs quiet during reset even with strobes present
        tag = "R1";
        csr_rd_en = 1; req_valid = 1; req_kind = 3'd1; csr_wr_en = 1; csr_wr_data = 8'h02;
        step();
        csr_rd_en = 1; req_valid = 1; step();
        rst = 0;
        rd();
        rq(1, 0, 1);
        rq(0, 0, 1);

        // R3: 06h from idle is not accepted
        tag = "R3";
        wr(8'h06); rd();
        // R2: arm write-enable, repeat keeps it
        tag = "R2";
        wr(8'h11); rd();
        wr(8'h02); rd(); wr(8'h02); rd();
        rq(1, 0, 0);
        // R3: arm register write
        tag = "R3";
        wr(8'h06); rd();
        // R4: commit lock 01 (byte 0Ah)
        tag = "R4";
        wr(8'h0A); rd();
        // R8: top-quarter lock boundary, sequence flag, pin
        tag = "R8";
        rq(0, 0, 1); rq(0, 1535, 1); rq(0, 1536, 1); rq(0, 2047, 1); rq(0, 0, 0);
        wp_pin = 1; rq(0, 0, 1); wp_pin = 0;
        // R10: locked field blocks nonvolatile potentiometer writes
        tag = "R10";
        rq(2, 0, 1);
        // R6: commit under pin is ignored
        tag = "R6";
        wp_pin = 1;
        wr(8'h06); rd();
        tag = "R11";
        rq(3, 0, 0); rq(4, 0, 1);
        tag = "R6";
        wr(8'h02); rd();
        wp_pin = 0;
        // R4: 02h,06h,02h clears the lock field; R7 read mid-sequence
        tag = "R7";
        wr(8'h06); rd(); rd();
        tag = "R11";
        rq(4, 0, 1); rq(4, 0, 0); rq(3, 0, 1);
        tag = "R4";
        wr(8'h02); rd();
        tag = "R10";
        rq(2, 0, 1); rq(2, 0, 0); wp_pin = 1; rq(2, 0, 1); wp_pin = 0;
        // R8: whole array and top-half locks
        tag = "R8";
        wr(8'h06); wr(8'h1A); rd();
        rq(0, 0, 1); rq(0, 1023, 1);
        wr(8'h06); wr(8'h12); rd();
        rq(0, 1023, 1); rq(0, 1024, 1);
        // R9: volatile potentiometer writes ignore pin, lock and flag
        tag = "R9";
        wp_pin = 1; rq(1, 2047, 0); wp_pin = 0;
        // R5: broken sequences clear latches, lock retained
        tag = "R5";
        wr(8'h55); rd();
        wr(8'h02); wr(8'h06); wr(8'h06); rd();
        wr(8'h02); wr(8'h00); rd();
        wr(8'h02); wr(8'h06); wr(8'h8A); rd();
        // R7: read and write in the same cycle return the pre-write image
        tag = "R7";
        csr_rd_en = 1; csr_wr_en = 1; csr_wr_data = 8'h02; step();
        rd();
        // R11: unknown kinds denied with everything enabled
        tag = "R11";
        wr(8'h06);
        rq(5, 0, 1); rq(6, 0, 1); rq(7, 0, 1);
        // R12: request coinciding with a write sees the prior state
        tag = "R12";
        wr(8'h00);
        req_valid = 1; req_kind = 3'd1; csr_wr_en = 1; csr_wr_data = 8'h02; step();
        rq(1, 0, 1);

        // weighted random traffic
        tag = "R5";
        for (int i = 0; i < 4000; i++) begin
            int pick = int'($urandom_range(0, 9));
            if ($urandom_range(0, 15) == 0) wp_pin = ~wp_pin;
            csr_rd_en = ($urandom_range(0, 2) == 0);
            req_valid = ($urandom_range(0, 1) == 1);
            req_kind  = 3'($urandom_range(0, 7));
            req_addr  = ADDR_W'($urandom);
            req_seq_ok = ($urandom_range(0, 3) != 0);
            if (pick < 3) begin
                csr_wr_en = 1; csr_wr_data = 8'h02;
            end else if (pick < 5) begin
                csr_wr_en = 1; csr_wr_data = 8'h06;
            end else if (pick < 7) begin
                csr_wr_en = 1; csr_wr_data = {3'b000, 2'($urandom_range(0, 3)), 3'b010};
            end else if (pick == 7) begin
                csr_wr_en = 1; csr_wr_data = 8'($urandom);
            end
            if (i == 2000) begin
                rst = 1; step(); rst = 0;
            end
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule